// File: doc/BRIEF.md
# Tagged-Word CRC-32C Engine

This block folds a list of 32-bit words into a 32-bit CRC. Each word is widened to a 37-bit unit before it enters the checksum: the word fills the low 32 bits and a 5-bit position tag is placed directly above it. A start command carries two counts. The pad count gives how many all-zero filler units are folded first. The word count gives how many real words follow. After the filler units, the engine asks the surrounding logic for the real words one at a time, from the highest 1-based index down to index 1. It does this over a request/valid handshake and waits as long as needed for each word. When the last unit has been folded, the engine raises a one-cycle done pulse, and the result is then held on its output.

The checksum is the reflected Castagnoli polynomial, consumed least-significant bit first. The register starts from zero and the result gets no final inversion. A parameter sets how many unit bits are folded per clock (1 to 37). Each unit therefore takes ceil(37/STEP_BITS) shift cycles, and the last cycle of a unit may fold fewer bits than the others.

The controller uses five states:
- IDLE: waiting for start.
- PICK: chooses the next unit.
- WAIT: a word has been requested.
- SHIFT: folding a unit.
- FINISH: done is high.

It has these transitions:
- IDLE→PICK on start.
- PICK→SHIFT when a filler unit remains.
- PICK→WAIT when a word remains.
- PICK→FINISH when nothing remains.
- WAIT→SHIFT when the word is valid.
- SHIFT→PICK on the unit's last slice.
- FINISH→IDLE unconditionally.

Top module: `crc37_engine`

## Requirements
- R1: The CRC register is cleared to zero on an accepted start. Unit bits are folded from bit 0 upward, using the reflected polynomial 0x82F63B78. The result gets no final XOR, so a single unit with data 0 and tag 1 gives 0x8AD958CF.
- R2: Each unit is 37 bits. Bits [31:0] hold the data word and bits [36:32] hold the tag.
- R3: With pad count P and word count N, P filler units with data 0 are folded first. Their tags run from P+N down to N+1.
- R4: After the filler units, word_req is raised with word_idx = k, for k running from N down to 1. word_idx is never 0 while word_req is high. The word is taken from word_data in a cycle where word_req and word_vld are both high, and it is folded with tag k.
- R5: While word_req is high and word_vld is low, word_req and word_idx hold their values. A stall of any length changes only the finishing time, never the result.
- R6: A start with N = 0 and P = 0 gives a result of 0. done is high in the cycle after the first edge following the capturing edge.
- R7: A start asserted while busy is high is ignored. It changes neither the result nor the finishing time of the job in progress.
- R8: done is high for exactly one cycle. After done, and also after reset, busy, done and word_req are low. crc_out stays stable until the next accepted start.
- R9: Tags are truncated to their low 5 bits before folding. For example, index 33 is folded with tag 1.
- R10: With no stalls, done is visible 1 + P·(1+C) + N·(2+C) edges after the capturing edge, where C = ceil(37/STEP_BITS).
- R11: For any counts and data, the result equals a bit-serial model of R1 to R3 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a job when idle |
| word_cnt | input | CNT_W | Number of real words N |
| pad_cnt | input | CNT_W | Number of zero filler units P |
| busy | output | 1 | High from the accepted start through the done cycle |
| word_req | output | 1 | A word is requested |
| word_idx | output | CNT_W | 1-based index of the requested word |
| word_vld | input | 1 | word_data holds the requested word |
| word_data | input | 32 | Requested data word |
| done | output | 1 | One-cycle completion pulse |
| crc_out | output | 32 | CRC result |

## Verification
The bench sets a start on a falling edge and then counts falling edges. With no stalls, done must appear at count 2 + P·(1+C) + N·(2+C); the bench checks the result and the count at that point. With stalls, each stall cycle adds exactly one to that count. The word responder drives word_vld on falling edges only. It flags any index that is out of the descending order. The idle and stability checks sample one cycle after done and again fifteen cycles later.

// File: rtl/crc37_pkg.sv
package crc37_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_WAIT,
        ST_SHIFT,
        ST_FINISH
    } crc37_state_e;

    localparam logic [31:0] CASTAGNOLI_REFL = 32'h82F6_3B78;

endpackage

// File: rtl/crc37_fold.sv
// Folds up to STEP bits into the CRC, least-significant first.
module crc37_fold #(
    parameter int          CRC_W = 32,
    parameter int          STEP  = 4,
    parameter logic [CRC_W-1:0] POLY = crc37_pkg::CASTAGNOLI_REFL,
    localparam int         NB_W  = $clog2(STEP + 1)
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [STEP-1:0]  din,
    input  logic [NB_W-1:0]  nbits,
    output logic [CRC_W-1:0] crc_nxt
);

    logic [CRC_W-1:0] chain [STEP+1];

    assign chain[0] = crc_in;

    for (genvar i = 0; i < STEP; i++) begin : g_bit
        logic use_bit;
        logic fb;
        assign use_bit = (nbits > NB_W'(i));
        assign fb      = chain[i][0] ^ din[i];
        assign chain[i+1] = !use_bit ? chain[i]
                          : ((chain[i] >> 1) ^ (fb ? POLY : '0));
    end

    assign crc_nxt = chain[STEP];

endmodule

// File: rtl/crc37_unit.sv
// Holds the unit being folded, the bits still to fold, and the CRC register.
module crc37_unit #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 5,
    parameter int CRC_W  = 32,
    parameter int STEP   = 4,
    parameter logic [CRC_W-1:0] POLY = crc37_pkg::CASTAGNOLI_REFL,
    localparam int UNIT_W = DATA_W + TAG_W,
    localparam int RW     = $clog2(UNIT_W + 1),
    localparam int NB_W   = $clog2(STEP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [TAG_W-1:0]  load_tag,
    input  logic              shift_en,
    output logic              last,
    output logic [CRC_W-1:0]  crc_q
);

    logic [UNIT_W-1:0] sh_q;
    logic [RW-1:0]     rem_q;
    logic [NB_W-1:0]   take;
    logic [STEP-1:0]   din;
    logic [CRC_W-1:0]  crc_nxt;

    for (genvar i = 0; i < STEP; i++) begin : g_din
        if (i < UNIT_W) begin : g_in
            assign din[i] = sh_q[i];
        end else begin : g_pad
            assign din[i] = 1'b0;
        end
    end

    always_comb begin
        if (rem_q > RW'(STEP)) begin
            take = NB_W'(STEP);
        end else begin
            take = NB_W'(rem_q);
        end
    end

    assign last = (rem_q <= RW'(STEP));

    crc37_fold #(
        .CRC_W (CRC_W),
        .STEP  (STEP),
        .POLY  (POLY)
    ) u_fold (
        .crc_in  (crc_q),
        .din     (din),
        .nbits   (take),
        .crc_nxt (crc_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            rem_q <= '0;
            crc_q <= '0;
        end else begin
            if (clear) begin
                crc_q <= '0;
            end else if (shift_en) begin
                crc_q <= crc_nxt;
            end
            if (load) begin
                sh_q  <= {load_tag, load_data};
                rem_q <= RW'(UNIT_W);
            end else if (shift_en) begin
                sh_q  <= sh_q >> STEP;
                rem_q <= rem_q - RW'(take);
            end
        end
    end

endmodule

// File: rtl/crc37_sched.sv
// Counts the filler units and words still to go, and forms their tags.
module crc37_sched #(
    parameter int CNT_W = 8,
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic [CNT_W-1:0] pad_in,
    input  logic             pad_take,
    input  logic             word_take,
    output logic             have_pad,
    output logic             have_word,
    output logic [TAG_W-1:0] pad_tag,
    output logic [TAG_W-1:0] word_tag,
    output logic [CNT_W-1:0] word_left
);

    logic [CNT_W-1:0] pad_left_q;
    logic [CNT_W-1:0] word_left_q;
    logic [CNT_W-1:0] word_total_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pad_left_q   <= '0;
            word_left_q  <= '0;
            word_total_q <= '0;
        end else if (arm) begin
            pad_left_q   <= pad_in;
            word_left_q  <= cnt_in;
            word_total_q <= cnt_in;
        end else begin
            if (pad_take) begin
                pad_left_q <= pad_left_q - 1'b1;
            end
            if (word_take) begin
                word_left_q <= word_left_q - 1'b1;
            end
        end
    end

    assign have_pad  = (pad_left_q != '0);
    assign have_word = (word_left_q != '0);
    // Low tag bits of a sum equal the sum of the low bits, modulo 2^TAG_W.
    assign pad_tag   = TAG_W'(pad_left_q) + TAG_W'(word_total_q);
    assign word_tag  = TAG_W'(word_left_q);
    assign word_left = word_left_q;

endmodule

// File: rtl/crc37_engine.sv
module crc37_engine #(
    parameter int DATA_W    = 32,
    parameter int TAG_W     = 5,
    parameter int CRC_W     = 32,
    parameter int CNT_W     = 8,
    parameter int STEP_BITS = 4,
    parameter logic [CRC_W-1:0] POLY = crc37_pkg::CASTAGNOLI_REFL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  word_cnt,
    input  logic [CNT_W-1:0]  pad_cnt,
    output logic              busy,
    output logic              word_req,
    output logic [CNT_W-1:0]  word_idx,
    input  logic              word_vld,
    input  logic [DATA_W-1:0] word_data,
    output logic              done,
    output logic [CRC_W-1:0]  crc_out
);

    import crc37_pkg::*;

    crc37_state_e state_q, state_d;

    logic             arm;
    logic             load_pad;
    logic             load_word;
    logic             shift_en;
    logic             unit_last;
    logic             have_pad;
    logic             have_word;
    logic [TAG_W-1:0] pad_tag;
    logic [TAG_W-1:0] word_tag;
    logic [CNT_W-1:0] word_left;
    logic [DATA_W-1:0] unit_data;
    logic [TAG_W-1:0]  unit_tag;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_PICK;
            ST_PICK: begin
                if (have_pad) begin
                    state_d = ST_SHIFT;
                end else if (have_word) begin
                    state_d = ST_WAIT;
                end else begin
                    state_d = ST_FINISH;
                end
            end
            ST_WAIT:   if (word_vld) state_d = ST_SHIFT;
            ST_SHIFT:  if (unit_last) state_d = ST_PICK;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        arm       = 1'b0;
        load_pad  = 1'b0;
        load_word = 1'b0;
        shift_en  = 1'b0;
        busy      = 1'b1;
        word_req  = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                arm  = start;
            end
            ST_PICK:   load_pad  = have_pad;
            ST_WAIT: begin
                word_req  = 1'b1;
                load_word = word_vld;
            end
            ST_SHIFT:  shift_en = 1'b1;
            ST_FINISH: done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    assign word_idx  = word_req ? word_left : '0;
    assign unit_data = load_word ? word_data : '0;
    assign unit_tag  = load_word ? word_tag : pad_tag;

    crc37_sched #(
        .CNT_W (CNT_W),
        .TAG_W (TAG_W)
    ) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .cnt_in    (word_cnt),
        .pad_in    (pad_cnt),
        .pad_take  (load_pad),
        .word_take (load_word),
        .have_pad  (have_pad),
        .have_word (have_word),
        .pad_tag   (pad_tag),
        .word_tag  (word_tag),
        .word_left (word_left)
    );

    crc37_unit #(
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W),
        .CRC_W  (CRC_W),
        .STEP   (STEP_BITS),
        .POLY   (POLY)
    ) u_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (arm),
        .load      (load_pad | load_word),
        .load_data (unit_data),
        .load_tag  (unit_tag),
        .shift_en  (shift_en),
        .last      (unit_last),
        .crc_q     (crc_out)
    );

endmodule

// File: rtl/crc37_engine_chk.sv
module crc37_engine_chk #(
    parameter int CNT_W = 8,
    parameter int CRC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             word_req,
    input logic             word_vld,
    input logic [CNT_W-1:0] word_idx,
    input logic [CRC_W-1:0] crc_out
);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_then_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !word_req));

    assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(crc_out));

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_req && !word_vld) |=> (word_req && $stable(word_idx)));

    assert_idx_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        word_req |-> (word_idx != '0));

    assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

bind crc37_engine crc37_engine_chk #(
    .CNT_W (CNT_W),
    .CRC_W (CRC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .word_req (word_req),
    .word_vld (word_vld),
    .word_idx (word_idx),
    .crc_out  (crc_out)
);

// File: tb/crc37_engine_bench.sv
module crc37_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int STEP  = 4;
    localparam int CNT_W = 8;
    localparam int C     = (37 + STEP - 1) / STEP;
    localparam logic [31:0] POLY = 32'h82F6_3B78;

    logic             clk;
    logic             rst_n;
    logic             start;
    logic [CNT_W-1:0] word_cnt;
    logic [CNT_W-1:0] pad_cnt;
    logic             busy;
    logic             word_req;
    logic [CNT_W-1:0] word_idx;
    logic             word_vld;
    logic [31:0]      word_data;
    logic             done;
    logic [31:0]      crc_out;

    logic [31:0] mem [0:255];
    int total = 0;
    int bad   = 0;
    int stall = 0;
    int wait_cnt = 0;
    int exp_idx = 0;
    int order_bad = 0;

    crc37_engine #(
        .CNT_W     (CNT_W),
        .STEP_BITS (STEP)
    ) u_crc37_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .word_cnt  (word_cnt),
        .pad_cnt   (pad_cnt),
        .busy      (busy),
        .word_req  (word_req),
        .word_idx  (word_idx),
        .word_vld  (word_vld),
        .word_data (word_data),
        .done      (done),
        .crc_out   (crc_out)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] fold_unit(input logic [31:0] c, input logic [31:0] d,
                                              input int tag);
        logic [36:0] u;
        logic [31:0] r;
        logic fb;
        logic [31:0] t32;
        t32 = tag;
        u = {t32[4:0], d};
        r = c;
        for (int b = 0; b < 37; b++) begin
            fb = r[0] ^ u[b];
            r = r >> 1;
            if (fb) r = r ^ POLY;
        end
        return r;
    endfunction

    function automatic logic [31:0] model(input int n, input int p);
        logic [31:0] c;
        c = '0;
        for (int j = p; j >= 1; j--) c = fold_unit(c, 32'h0, j + n);
        for (int k = n; k >= 1; k--) c = fold_unit(c, mem[k], k);
        return c;
    endfunction

    function automatic int due(input int n, input int p, input int st);
        return 2 + p * (1 + C) + n * (2 + C + st);
    endfunction

    // Word responder: drives only on falling edges.
    initial begin
        word_vld  = 1'b0;
        word_data = '0;
        forever begin
            @(negedge clk);
            if (word_req) begin
                if (!word_vld) begin
                    if (wait_cnt >= stall) begin
                        word_vld  = 1'b1;
                        word_data = mem[word_idx];
                        if (int'(word_idx) != exp_idx) order_bad++;
                        exp_idx--;
                        wait_cnt = 0;
                    end else begin
                        wait_cnt++;
                    end
                end
            end else begin
                word_vld = 1'b0;
            end
        end
    end

    task automatic run(input int n, input int p, input int st, input int inj,
                       output logic [31:0] res, output int cyc);
        stall     = st;
        wait_cnt  = 0;
        exp_idx   = n;
        order_bad = 0;
        @(negedge clk);
        word_cnt = CNT_W'(n);
        pad_cnt  = CNT_W'(p);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 6000) begin
            @(negedge clk);
            cyc++;
            if (cyc == inj) begin
                start    = 1'b1;
                word_cnt = 8'd9;
                pad_cnt  = 8'd0;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        res = crc_out;
        if (!done) check(1'b0, "timeout", 32'(cyc), 32'(due(n, p, st)));
    endtask

    task automatic t_reset;
        check(busy == 1'b0, "R8 reset busy", 32'(busy), 32'h0);
        check(done == 1'b0, "R8 reset done", 32'(done), 32'h0);
        check(word_req == 1'b0, "R8 reset word_req", 32'(word_req), 32'h0);
        check(crc_out == 32'h0, "R1 reset crc", crc_out, 32'h0);
    endtask

    task automatic t_empty;
        logic [31:0] r; int cy;
        run(0, 0, 0, -1, r, cy);
        check(r == 32'h0, "R6 empty crc", r, 32'h0);
        check(cy == 2, "R6 empty latency", 32'(cy), 32'd2);
    endtask

    task automatic t_known;
        logic [31:0] r; int cy;
        run(0, 1, 0, -1, r, cy);
        check(r == 32'h8AD9_58CF, "R1 single filler known value", r, 32'h8AD9_58CF);
        check(cy == due(0, 1, 0), "R10 filler latency", 32'(cy), 32'(due(0, 1, 0)));
    endtask

    task automatic t_word;
        logic [31:0] r; int cy;
        mem[1] = 32'h0;
        run(1, 0, 0, -1, r, cy);
        check(r == 32'h8AD9_58CF, "R2 zero word tag 1", r, 32'h8AD9_58CF);
        mem[1] = 32'hFFFF_FFFF;
        run(1, 0, 0, -1, r, cy);
        check(r == model(1, 0), "R2 all-ones word", r, model(1, 0));
        mem[1] = 32'h1234_5678; mem[2] = 32'h8000_0001;
        run(2, 0, 0, -1, r, cy);
        check(r == model(2, 0), "R2 two words", r, model(2, 0));
    endtask

    task automatic t_order;
        logic [31:0] r; int cy;
        for (int k = 1; k <= 6; k++) mem[k] = 32'hA5A5_0000 + 32'(k * 17);
        run(6, 0, 0, -1, r, cy);
        check(order_bad == 0, "R4 descending index order", 32'(order_bad), 32'h0);
        check(r == model(6, 0), "R4 six words", r, model(6, 0));
        check(cy == due(6, 0, 0), "R10 word latency", 32'(cy), 32'(due(6, 0, 0)));
    endtask

    task automatic t_pad;
        logic [31:0] r; int cy;
        for (int k = 1; k <= 3; k++) mem[k] = 32'h0F0F_0000 ^ 32'(k);
        run(3, 4, 0, -1, r, cy);
        check(r == model(3, 4), "R3 fillers before words", r, model(3, 4));
        check(cy == due(3, 4, 0), "R10 mixed latency", 32'(cy), 32'(due(3, 4, 0)));
    endtask

    task automatic t_stall;
        logic [31:0] r; int cy;
        for (int k = 1; k <= 5; k++) mem[k] = 32'hDEAD_0000 + 32'(k);
        run(5, 2, 3, -1, r, cy);
        check(r == model(5, 2), "R5 stalled result", r, model(5, 2));
        check(cy == due(5, 2, 3), "R5 stall latency", 32'(cy), 32'(due(5, 2, 3)));
        check(order_bad == 0, "R5 index held order", 32'(order_bad), 32'h0);
    endtask

    task automatic t_trunc;
        logic [31:0] r; int cy;
        for (int k = 1; k <= 40; k++) mem[k] = 32'(k * 32'h0101_0101);
        run(40, 3, 0, -1, r, cy);
        check(r == model(40, 3), "R9 truncated tags", r, model(40, 3));
    endtask

    task automatic t_busy_start;
        logic [31:0] r; int cy;
        for (int k = 1; k <= 9; k++) mem[k] = 32'h7777_0000 + 32'(k);
        run(4, 1, 0, 4, r, cy);
        check(r == model(4, 1), "R7 restart ignored result", r, model(4, 1));
        check(cy == due(4, 1, 0), "R7 restart ignored latency", 32'(cy), 32'(due(4, 1, 0)));
    endtask

    task automatic t_stable;
        logic [31:0] r; int cy;
        mem[1] = 32'hCAFE_F00D; mem[2] = 32'h0BAD_BEEF;
        run(2, 1, 0, -1, r, cy);
        @(negedge clk);
        check(done == 1'b0, "R8 done one cycle", 32'(done), 32'h0);
        check(busy == 1'b0, "R8 idle after done", 32'(busy), 32'h0);
        repeat (15) @(negedge clk);
        check(crc_out == r, "R8 result held", crc_out, r);
        check(word_req == 1'b0, "R8 no request when idle", 32'(word_req), 32'h0);
    endtask

    task automatic t_random;
        logic [31:0] r; int cy; int n; int p; int st;
        for (int it = 0; it < 12; it++) begin
            n  = $urandom_range(20, 0);
            p  = $urandom_range(6, 0);
            st = $urandom_range(2, 0);
            for (int k = 1; k <= n; k++) mem[k] = $urandom;
            run(n, p, st, -1, r, cy);
            check(r == model(n, p), "R11 random vs model", r, model(n, p));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd150000, 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 256; k++) mem[k] = '0;
        rst_n    = 1'b0;
        start    = 1'b0;
        word_cnt = '0;
        pad_cnt  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty();
        t_known();
        t_word();
        t_order();
        t_pad();
        t_stall();
        t_trunc();
        t_busy_start();
        t_stable();
        t_random();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule